// File: doc/BRIEF.md
# Quad Double-Buffered Serial DAC Front End

This block is the digital side of a four-channel, 8-bit converter. A host moves 12-bit command words in serially while chip-select is held low. The word sits in a shift register until chip-select rises. At that moment the word is decoded and applied to a pair of registers per channel: a staging (input) register and an output (DAC) register. The DAC register values leave the block as a flat bus that feeds the analog converters.

Commands can do the following:
- stage one channel,
- load one channel straight through both registers,
- load every DAC register with one byte,
- transfer all staged values at once,
- do nothing, or
- pick the serial-out clock phase.

The bit leaving the far end of the shift register is driven on `dout`. A second device can therefore take its serial input from it, which allows several parts to be chained on one chip-select. An active-low transfer pin copies all staged values to the outputs for as long as it is held low.

All pins are sampled by the system clock `clk` through a short synchronizer. The serial clock must therefore run well below `clk`.

Top module: `sdac_top`

## Requirements
- R1: A command word takes effect only at the rising edge of `csN`. While `csN` is low, no input or DAC register changes because of shifting. Bits enter on `sclk` rising edges while `csN` is low. The first bit received becomes word bit 11. The fields are: bits 11:10 = channel address, bits 9:8 = control code, bits 7:0 = data byte (bit 7 is the MSB).
- R2: Control code 01 loads the data byte into the input register of the addressed channel. No DAC register changes.
- R3: Control code 11 loads the data byte into both the input register and the DAC register of the addressed channel. Other channels are unchanged.
- R4: Control code 10 (address ignored) loads the data byte into all four DAC registers and leaves every input register unchanged. Data 0x00 clears all outputs.
- R5: Control code 00 with address 01 copies every input register into its DAC register.
- R6: Control code 00 with address 00 is a no-operation. Its data byte changes no input or DAC register.
- R7: Control code 00 with address 10 selects rising-phase output, in which `dout` changes after `sclk` rising edges. It also performs the R5 transfer. Rising phase is the state after reset.
- R8: Control code 00 with address 11 selects falling-phase output, in which `dout` changes only after `sclk` falling edges. It performs no transfer.
- R9: While `ldacN` is low, every DAC register follows its input register, including input registers written during that time.
- R10: `dout` presents the bits that were in the shift register before a frame, most significant first, one per `sclk` cycle. The input word therefore reappears at `dout` 12 clock periods later.
- R11: If a frame is longer or shorter than 12 bits, the last 12 bits received (including bits from earlier frames) form the executed word.
- R12: After reset, all input registers, all DAC registers and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| csN | input | 1 | Active-low chip-select; its rising edge executes the word |
| din | input | 1 | Serial data in |
| ldacN | input | 1 | Active-low level transfer of all input registers to DAC registers |
| dout | output | 1 | Serial data out for chaining |
| dacCode | output | 32 | DAC register values; channel n at bits [8n+7:8n] |

## Verification
The assertions take for granted that `sclk`, `csN`, `din` and `ldacN` are slow next to `clk`. Each level must last several clock cycles, so that every synchronized edge is seen once and `csN` never rises in the same sampled cycle as an `sclk` edge. They also assume `din` is settled before the `sclk` rising edge that takes it. The stimulus holds every pin level for at least six clock cycles, changes `din` only while `sclk` is low, and moves `csN` only while `sclk` is low.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  parameter int CH_COUNT = 4;
  parameter int DATA_W   = 8;
  parameter int ADDR_W   = $clog2(CH_COUNT);
  parameter int CTL_W    = 2;
  parameter int WORD_W   = ADDR_W + CTL_W + DATA_W;

  // control field codes
  localparam logic [CTL_W-1:0] CTL_GLOBAL    = 2'b00;
  localparam logic [CTL_W-1:0] CTL_PRELOAD   = 2'b01;
  localparam logic [CTL_W-1:0] CTL_BROADCAST = 2'b10;
  localparam logic [CTL_W-1:0] CTL_DIRECT    = 2'b11;

  // global operation selected by address field when control is CTL_GLOBAL
  localparam logic [1:0] OP_NOP        = 2'b00;
  localparam logic [1:0] OP_XFER       = 2'b01;
  localparam logic [1:0] OP_PHASE_RISE = 2'b10;
  localparam logic [1:0] OP_PHASE_FALL = 2'b11;

  typedef struct packed {
    logic [CH_COUNT-1:0] loadIn;   // write input register of channel
    logic [CH_COUNT-1:0] loadDac;  // write DAC register of channel from data
    logic                swXfer;   // command-driven transfer of all channels
    logic                ldacHold; // pin-driven transfer, level
    logic [DATA_W-1:0]   data;
  } strobe_t;
endpackage

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclk,
  input  logic    csN,
  input  logic    din,
  input  logic    ldacN,
  output strobe_t strb,
  output logic    dout
);
  localparam int PIN_N = 4;
  // pin bundle order: {csN, ldacN, sclk, din}
  localparam int P_CS   = 3;
  localparam int P_LDAC = 2;
  localparam int P_SCLK = 1;
  localparam int P_DIN  = 0;
  localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1100;
  localparam int DATA_LSB = 0;
  localparam int CTL_LSB  = DATA_W;
  localparam int ADDR_LSB = DATA_W + CTL_W;

  logic [PIN_N-1:0] syncPipe [SYNC_STAGES];
  logic [PIN_N-1:0] pinNow;
  logic [PIN_N-1:0] pinPrev;
  logic sclkRise, sclkFall, csRise, csLow;
  logic [WORD_W-1:0] shiftReg;
  logic outBit;
  logic fallBit;
  logic phaseRise;
  logic [ADDR_W-1:0] addrField;
  logic [CTL_W-1:0]  ctlField;
  logic [DATA_W-1:0] dataField;

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= PIN_IDLE;
      pinPrev <= PIN_IDLE;
    end else begin
      syncPipe[0] <= {csN, ldacN, sclk, din};
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      pinPrev <= syncPipe[SYNC_STAGES-1];
    end
  end

  assign pinNow   = syncPipe[SYNC_STAGES-1];
  assign csLow    = ~pinNow[P_CS];
  assign sclkRise = pinNow[P_SCLK] & ~pinPrev[P_SCLK];
  assign sclkFall = ~pinNow[P_SCLK] & pinPrev[P_SCLK];
  assign csRise   = pinNow[P_CS] & ~pinPrev[P_CS];

  // shift register and serial out
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      outBit   <= 1'b0;
      fallBit  <= 1'b0;
    end else begin
      if (sclkRise && csLow) begin
        shiftReg <= {shiftReg[WORD_W-2:0], pinNow[P_DIN]};
        outBit   <= shiftReg[WORD_W-1];
      end
      if (sclkFall && csLow) begin
        fallBit <= outBit;
      end
    end
  end

  assign addrField = shiftReg[ADDR_LSB +: ADDR_W];
  assign ctlField  = shiftReg[CTL_LSB +: CTL_W];
  assign dataField = shiftReg[DATA_LSB +: DATA_W];

  // output phase selection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseRise <= 1'b1;
    end else if (csRise && ctlField == CTL_GLOBAL) begin
      if (addrField == ADDR_W'(OP_PHASE_RISE)) phaseRise <= 1'b1;
      else if (addrField == ADDR_W'(OP_PHASE_FALL)) phaseRise <= 1'b0;
    end
  end

  assign dout = phaseRise ? outBit : fallBit;

  // command decode into strobes
  always_comb begin
    strb          = '0;
    strb.data     = dataField;
    strb.ldacHold = ~pinNow[P_LDAC];
    if (csRise) begin
      case (ctlField)
        CTL_PRELOAD: strb.loadIn = CH_COUNT'(1) << addrField;
        CTL_DIRECT: begin
          strb.loadIn  = CH_COUNT'(1) << addrField;
          strb.loadDac = CH_COUNT'(1) << addrField;
        end
        CTL_BROADCAST: strb.loadDac = '1;
        default: begin
          if (addrField == ADDR_W'(OP_XFER) || addrField == ADDR_W'(OP_PHASE_RISE))
            strb.swXfer = 1'b1;
        end
      endcase
    end
  end

  // R7 R8
  // phase setting only moves on an executed word
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csRise |=> $stable(phaseRise));

  // R1
  // shift register frozen while deselected
  shift_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csLow |=> $stable(shiftReg));

  // R10
  // serial output moves only after a serial clock edge or a phase change
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkRise && !sclkFall && !csRise) |=> $stable(dout));

  // R2
  // at most one input register written per word
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.loadIn));
endmodule

// File: rtl/sdac_datapath.sv
module sdac_datapath
  import sdac_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  output logic [CH_COUNT*DATA_W-1:0] dacFlat
);
  logic [DATA_W-1:0] inReg  [CH_COUNT];
  logic [DATA_W-1:0] dacReg [CH_COUNT];
  logic xferAll;

  assign xferAll = strb.swXfer | strb.ldacHold;

  for (genvar ch = 0; ch < CH_COUNT; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg[ch]  <= '0;
        dacReg[ch] <= '0;
      end else begin
        if (strb.loadIn[ch]) inReg[ch] <= strb.data;
        if (strb.loadDac[ch]) dacReg[ch] <= strb.data;
        else if (xferAll) dacReg[ch] <= inReg[ch];
      end
    end

    assign dacFlat[ch*DATA_W +: DATA_W] = dacReg[ch];

    // R2
    // staging without transfer leaves the output alone
    stage_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.loadDac[ch] && !xferAll) |=> $stable(dacReg[ch]));

    // R3
    // a direct or broadcast load lands the data byte
    direct_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadDac[ch] |=> dacReg[ch] == $past(strb.data));

    // R5
    // a transfer copies the staged value
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
      (xferAll && !strb.loadDac[ch]) |=> dacReg[ch] == $past(inReg[ch]));

    // R4
    // input register untouched unless addressed
    in_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadIn[ch] |=> $stable(inReg[ch]));
  end
endmodule

// File: rtl/sdac_top.sv
module sdac_top
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       csN,
  input  logic                       din,
  input  logic                       ldacN,
  output logic                       dout,
  output logic [CH_COUNT*DATA_W-1:0] dacCode
);
  strobe_t strb;

  sdac_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclk  (sclk),
    .csN   (csN),
    .din   (din),
    .ldacN (ldacN),
    .strb  (strb),
    .dout  (dout)
  );

  sdac_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dacFlat (dacCode)
  );
endmodule

// File: tb/test_sdac_top.sv
`timescale 1ns/1ps
module test_sdac_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic din = 1'b0;
  logic ldacN = 1'b1;
  logic dout;
  logic [31:0] dacCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic hiOut [32];
  logic loOut [32];

  always #10 clk = ~clk;

  sdac_top i_sdac_top (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .ldacN(ldacN), .dout(dout), .dacCode(dacCode)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkDac(input string req, input logic [7:0] d0, input logic [7:0] d1,
                        input logic [7:0] d2, input logic [7:0] d3);
    chk(req, dacCode, {d3, d2, d1, d0});
  endtask

  // shift n bits (MSB of the low n first), recording dout per phase
  task automatic shiftBits(input logic [31:0] bits, input int n);
    for (int k = 0; k < n; k++) begin
      din = bits[n-1-k];
      waitClk(6);
      sclk = 1'b1;
      waitClk(8);
      hiOut[k] = dout;
      sclk = 1'b0;
      waitClk(8);
      loOut[k] = dout;
    end
  endtask

  task automatic frame(input logic [31:0] bits, input int n);
    csN = 1'b0;
    waitClk(6);
    shiftBits(bits, n);
    csN = 1'b1;
    waitClk(10);
  endtask

  task automatic word(input logic [1:0] a, input logic [1:0] c, input logic [7:0] d);
    frame({20'd0, a, c, d}, 12);
  endtask

  task automatic chkRisePhase(input string req, input logic [11:0] prev);
    int bad = 0;
    for (int k = 0; k < 12; k++)
      if (hiOut[k] !== prev[11-k] || loOut[k] !== prev[11-k]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic chkFallPhase(input string req, input logic [11:0] prev);
    int bad = 0;
    for (int k = 0; k < 12; k++) begin
      if (loOut[k] !== prev[11-k]) bad++;
      if (k > 0 && hiOut[k] !== prev[12-k]) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic testReset();
    chkDac("R12 reset dac", 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R12 reset dout", dout, 0);
  endtask

  task automatic testPreloadXfer();
    word(2'b10, 2'b01, 8'hA5);
    chkDac("R2 preload keeps dac", 8'h00, 8'h00, 8'h00, 8'h00);
    word(2'b01, 2'b00, 8'h00);
    chkDac("R5 sw transfer", 8'h00, 8'h00, 8'hA5, 8'h00);
  endtask

  task automatic testDirect();
    word(2'b11, 2'b11, 8'h3C);
    chkDac("R3 direct load", 8'h00, 8'h00, 8'hA5, 8'h3C);
  endtask

  task automatic testBroadcast();
    word(2'b01, 2'b10, 8'h77);
    chkDac("R4 broadcast", 8'h77, 8'h77, 8'h77, 8'h77);
    word(2'b01, 2'b00, 8'h00);
    chkDac("R4 inputs kept after broadcast", 8'h00, 8'h00, 8'hA5, 8'h3C);
    word(2'b00, 2'b10, 8'h00);
    chkDac("R4 broadcast clear", 8'h00, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic testNop();
    word(2'b00, 2'b01, 8'h11);
    word(2'b00, 2'b00, 8'hFF);
    chkDac("R6 nop dac", 8'h00, 8'h00, 8'h00, 8'h00);
    word(2'b01, 2'b00, 8'h00);
    chkDac("R6 nop inputs", 8'h11, 8'h00, 8'hA5, 8'h3C);
  endtask

  task automatic testFrameGate();
    csN = 1'b0;
    waitClk(6);
    shiftBits({20'd0, 2'b01, 2'b11, 8'h99}, 12);
    waitClk(10);
    chkDac("R1 no effect before cs rise", 8'h11, 8'h00, 8'hA5, 8'h3C);
    csN = 1'b1;
    waitClk(10);
    chkDac("R1 effect at cs rise", 8'h11, 8'h99, 8'hA5, 8'h3C);
  endtask

  task automatic testLength();
    frame(32'hF342, 16);
    chkDac("R11 long frame", 8'h42, 8'h99, 8'hA5, 8'h3C);
    word(2'b00, 2'b00, 8'hB0);
    frame(32'h5, 4);
    chkDac("R11 short frame", 8'h42, 8'h99, 8'h05, 8'h3C);
  endtask

  task automatic testPhase();
    word(2'b00, 2'b00, 8'h5A);
    word(2'b00, 2'b00, 8'hC3);
    chkRisePhase("R10 R7 default rise phase chain", 12'h05A);
    word(2'b01, 2'b01, 8'h66);
    word(2'b11, 2'b00, 8'h00);
    chkDac("R8 fall phase no transfer", 8'h42, 8'h99, 8'h05, 8'h3C);
    word(2'b00, 2'b00, 8'hC3);
    chkFallPhase("R8 fall phase dout", 12'hC00);
    word(2'b10, 2'b00, 8'h00);
    chkDac("R7 rise phase transfer", 8'h42, 8'h66, 8'h05, 8'h3C);
    word(2'b00, 2'b00, 8'hC3);
    chkRisePhase("R7 R10 rise phase restored", 12'h800);
  endtask

  task automatic testLdacPin();
    word(2'b11, 2'b01, 8'hE1);
    chkDac("R2 preload before pin", 8'h42, 8'h66, 8'h05, 8'h3C);
    ldacN = 1'b0;
    waitClk(10);
    chkDac("R9 pin transfer", 8'h42, 8'h66, 8'h05, 8'hE1);
    word(2'b00, 2'b01, 8'h0F);
    chkDac("R9 follows while low", 8'h0F, 8'h66, 8'h05, 8'hE1);
    ldacN = 1'b1;
    waitClk(10);
    word(2'b00, 2'b01, 8'hAA);
    chkDac("R9 released no follow", 8'h0F, 8'h66, 8'h05, 8'hE1);
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    testReset();
    testPreloadXfer();
    testDirect();
    testBroadcast();
    testNop();
    testFrameGate();
    testLength();
    testPhase();
    testLdacPin();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule